// File: doc/BRIEF.md
# Second-Operand Shifter and Literal Rotator

This block builds the second ALU operand of a data-processing instruction. It takes the low twelve bits of the instruction word, the operand-kind bit, the value of the source register, the low byte of the shift-count register and the current carry flag. From these it produces a 32-bit operand and a shifter carry-out. Both outputs are registered, so they appear one clock after the inputs are presented.

In literal form an 8-bit constant is rotated right by twice a 4-bit count. In register form the source register value is shifted by one of four shift kinds. The distance comes from either a 5-bit field of the instruction or the low byte of a second register.

Register file reads, the ALU and flag writeback happen outside the block. The surrounding pipeline reads the registers named in bits 3-0 and 11-8 and passes in their values.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst_n` is low, `op_out` and `c_out` are 0. Otherwise both take the result for the inputs present at each rising clock edge, so results appear one cycle after their inputs.
- R2: With `imm_sel`=1, `op_out` is `field[7:0]` zero-extended and rotated right by 2*`field[11:8]`. For example, field 0xEFF gives 0x00000FF0.
- R3: With `imm_sel`=1, `c_out` equals `c_in` when `field[11:8]` is 0, and otherwise equals bit 31 of the rotated result.
- R4: With `imm_sel`=0 and `field[4]`=0, the distance is `field[11:7]`. The kind comes from `field[6:5]`: 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right.
- R5: With `imm_sel`=0 and `field[4]`=1, the distance is `rs_low` (the low byte of the register named by `field[11:8]`), applied to `rm_val` (the register named by `field[3:0]`). For example, field 0x332 gives `rm_val` shifted logically right by `rs_low`.
- R6: In register form, a distance of 0 gives `op_out`=`rm_val` and `c_out`=`c_in`, whatever the kind.
- R7: For a distance n from 1 to 31, `c_out` is the last bit shifted out. That is `rm_val[32-n]` for a left shift and `rm_val[n-1]` for the other kinds.
- R8: For a left or logical right shift, a distance of 32 gives 0 with carry `rm_val[0]` (left) or `rm_val[31]` (right). A distance above 32 gives 0 with carry 0.
- R9: An arithmetic right shift by 32 or more fills every bit with `rm_val[31]`, and `c_out` is `rm_val[31]`.
- R10: A rotate by a nonzero register distance uses the distance modulo 32. A nonzero multiple of 32 returns `rm_val` with `c_out`=`rm_val[31]`.
- R11: When `field[4]`=1, `field[7]` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_sel | input | 1 | Operand kind (instruction bit 25): 1 literal, 0 register |
| field | input | 12 | Instruction bits 11-0 |
| rm_val | input | 32 | Value of the source register |
| rs_low | input | 8 | Low byte of the shift-count register |
| c_in | input | 1 | Current carry flag |
| op_out | output | 32 | Registered second operand |
| c_out | output | 1 | Registered shifter carry-out |

## Verification
Every result passes through a single register, so the operand and the carry for a set of inputs are both due at the first rising edge after those inputs are driven. The bench drives inputs on a falling edge and samples both outputs on the following falling edge, which is half a period after the capturing edge. The assertions state the same one-cycle relation, using `|=>` and `$past` of the inputs. Reset behaviour is checked while reset is still asserted, before any result is captured.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int XLEN  = 32;
  localparam int AMTW  = 8;
  localparam int IMMW  = 8;
  localparam int ROTW  = 4;
  localparam int SAMTW = $clog2(XLEN);

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;

  typedef struct packed {
    logic            cy;
    logic [XLEN-1:0] val;
  } sh_res_t;

  // Rotate right by n (0..XLEN-1); a zero rotate keeps the incoming carry.
  function automatic sh_res_t rot_right(logic [XLEN-1:0] v, logic [SAMTW-1:0] n, logic cin);
    sh_res_t r;
    int      k;
    k = int'(n);
    if (k == 0) begin
      r.val = v;
      r.cy  = cin;
    end else begin
      r.val = (v >> k) | (v << (XLEN - k));
      r.cy  = v[k-1];
    end
    return r;
  endfunction

  // Shift of any kind by an 8-bit distance, covering distances past the word width.
  function automatic sh_res_t shift_any(logic [XLEN-1:0] v, sh_kind_e kind,
                                        logic [AMTW-1:0] amt, logic cin);
    sh_res_t r;
    int      a;
    a     = int'(amt);
    r.val = v;
    r.cy  = cin;
    if (a != 0) begin
      unique case (kind)
        SH_LSL: begin
          if (a < XLEN) begin
            r.val = v << a;
            r.cy  = v[XLEN-a];
          end else begin
            r.val = '0;
            r.cy  = (a == XLEN) ? v[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (a < XLEN) begin
            r.val = v >> a;
            r.cy  = v[a-1];
          end else begin
            r.val = '0;
            r.cy  = (a == XLEN) ? v[XLEN-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (a < XLEN) begin
            r.val = $unsigned($signed(v) >>> a);
            r.cy  = v[a-1];
          end else begin
            r.val = {XLEN{v[XLEN-1]}};
            r.cy  = v[XLEN-1];
          end
        end
        default: begin
          if (amt[SAMTW-1:0] == '0) begin
            r.val = v;
            r.cy  = v[XLEN-1];
          end else begin
            r = rot_right(v, amt[SAMTW-1:0], cin);
          end
        end
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/opsh_litrot.sv
module opsh_litrot
  import opsh_pkg::*;
(
  input  logic [IMMW+ROTW-1:0] lit_field,
  input  logic                 cin,
  output sh_res_t              lit_res,
  output logic                 rot_zero
);
  logic [IMMW-1:0]  lit_byte;
  logic [ROTW-1:0]  half_rot;
  logic [SAMTW-1:0] full_rot;

  assign lit_byte = lit_field[IMMW-1:0];
  assign half_rot = lit_field[IMMW+ROTW-1:IMMW];
  assign full_rot = {half_rot, 1'b0};
  assign rot_zero = (half_rot == '0);

  always_comb begin
    lit_res = rot_right({{(XLEN-IMMW){1'b0}}, lit_byte}, full_rot, cin);
  end
endmodule

// File: rtl/opsh_amtsel.sv
module opsh_amtsel
  import opsh_pkg::*;
(
  input  logic             amt_from_reg,
  input  logic [SAMTW-1:0] amt_field,
  input  logic [AMTW-1:0]  amt_reg,
  output logic [AMTW-1:0]  amt_sel,
  output logic             amt_zero
);
  always_comb begin
    if (amt_from_reg) amt_sel = amt_reg;
    else              amt_sel = {{(AMTW-SAMTW){1'b0}}, amt_field};
  end
  assign amt_zero = (amt_sel == '0);
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
(
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      kind_bits,
  input  logic [AMTW-1:0] amt,
  input  logic            cin,
  output sh_res_t         sh_res
);
  sh_kind_e kind;
  assign kind = sh_kind_e'(kind_bits);

  always_comb begin
    sh_res = shift_any(src, kind, amt, cin);
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opsh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imm_sel,
  input  logic [11:0]     field,
  input  logic [XLEN-1:0] rm_val,
  input  logic [AMTW-1:0] rs_low,
  input  logic            c_in,
  output logic [XLEN-1:0] op_out,
  output logic            c_out
);
  sh_res_t         lit_res;
  sh_res_t         sh_res;
  sh_res_t         next_res;
  logic            rot_zero;
  logic [AMTW-1:0] amt_sel;
  logic            amt_zero;
  logic            amt_from_reg;

  assign amt_from_reg = field[4];

  opsh_litrot u_lit (
    .lit_field (field),
    .cin       (c_in),
    .lit_res   (lit_res),
    .rot_zero  (rot_zero)
  );

  opsh_amtsel u_amt (
    .amt_from_reg (amt_from_reg),
    .amt_field    (field[11:7]),
    .amt_reg      (rs_low),
    .amt_sel      (amt_sel),
    .amt_zero     (amt_zero)
  );

  opsh_barrel u_bar (
    .src       (rm_val),
    .kind_bits (field[6:5]),
    .amt       (amt_sel),
    .cin       (c_in),
    .sh_res    (sh_res)
  );

  assign next_res = imm_sel ? lit_res : sh_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_out <= '0;
      c_out  <= 1'b0;
    end else begin
      op_out <= next_res.val;
      c_out  <= next_res.cy;
    end
  end
endmodule

// File: rtl/opsh_chk.sv
module opsh_chk
  import opsh_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            imm_sel,
  input logic [11:0]     field,
  input logic [XLEN-1:0] rm_val,
  input logic [AMTW-1:0] rs_low,
  input logic            c_in,
  input logic [XLEN-1:0] op_out,
  input logic            c_out,
  input logic            rot_zero,
  input logic            amt_zero
);
  // R3
  lit_norot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_sel && field[11:8] == 4'd0) |=>
      (c_out == $past(c_in) && op_out == {{(XLEN-IMMW){1'b0}}, $past(field[7:0])}));

  // R2
  lit_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |=> ($countones(op_out) == $countones($past(field[7:0]))));

  // R3
  lit_rotflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_sel && !rot_zero) |=> (c_out == op_out[XLEN-1]));

  // R6
  zero_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && amt_zero) |=> (op_out == $past(rm_val) && c_out == $past(c_in)));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && field[4] && !field[6] && rs_low > 8'd32) |=> (op_out == '0 && !c_out));

  // R9
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && field[4] && field[6:5] == 2'b10 && rs_low >= 8'd32) |=>
      (op_out == {XLEN{$past(rm_val[XLEN-1])}} && c_out == $past(rm_val[XLEN-1])));
endmodule

bind opnd_shifter opsh_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .imm_sel  (imm_sel),
  .field    (field),
  .rm_val   (rm_val),
  .rs_low   (rs_low),
  .c_in     (c_in),
  .op_out   (op_out),
  .c_out    (c_out),
  .rot_zero (rot_zero),
  .amt_zero (amt_zero)
);

// File: tb/sim_opnd_shifter.sv
module sim_opnd_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imm_sel = 1'b0;
  logic [11:0] field = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_low = '0;
  logic        c_in = 1'b0;
  logic [31:0] op_out;
  logic        c_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_shifter u0 (
    .clk(clk), .rst_n(rst_n), .imm_sel(imm_sel), .field(field),
    .rm_val(rm_val), .rs_low(rs_low), .c_in(c_in),
    .op_out(op_out), .c_out(c_out)
  );

  // Bit-at-a-time reference: each step moves one bit out and records it as carry.
  function automatic logic [32:0] ref_model(logic sel, logic [11:0] f, logic [31:0] rm,
                                            logic [7:0] rs, logic cin);
    logic [31:0] r;
    logic        c;
    int          n;
    c = cin;
    if (sel) begin
      r = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) begin
        c = r[0];
        r = {r[0], r[31:1]};
      end
    end else begin
      r = rm;
      n = f[4] ? int'(rs) : int'(f[11:7]);
      for (int i = 0; i < n; i++) begin
        case (f[6:5])
          2'b00: begin c = r[31]; r = {r[30:0], 1'b0}; end
          2'b01: begin c = r[0];  r = {1'b0, r[31:1]}; end
          2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
    return {c, r};
  endfunction

  task automatic check(string tag, logic [32:0] exp);
    checks++;
    if ({c_out, op_out} !== exp) begin
      errors++;
      $display("FAIL %s: got c=%0b op=%08h expected c=%0b op=%08h",
               tag, c_out, op_out, exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(string tag, logic sel, logic [11:0] f, logic [31:0] rm,
                       logic [7:0] rs, logic cin);
    @(negedge clk);
    imm_sel = sel; field = f; rm_val = rm; rs_low = rs; c_in = cin;
    @(negedge clk);
    check(tag, ref_model(sel, f, rm, rs, cin));
  endtask

  task automatic apply_exp(string tag, logic sel, logic [11:0] f, logic [31:0] rm,
                           logic [7:0] rs, logic cin, logic [32:0] exp);
    @(negedge clk);
    imm_sel = sel; field = f; rm_val = rm; rs_low = rs; c_in = cin;
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [32:0] first;
    logic [7:0]  rs_pick [6];
    void'($urandom(32'd4242));
    rs_pick = '{8'd0, 8'd31, 8'd32, 8'd33, 8'd64, 8'd255};

    // R1: outputs stay 0 under reset even with live inputs
    imm_sel = 1'b1; field = 12'h0FF; c_in = 1'b1; rm_val = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    check("R1 reset", 33'd0);
    rst_n = 1'b1;

    // R2, R3: literal forms
    apply_exp("R2 literal EFF", 1'b1, 12'hEFF, 32'd0, 8'd0, 1'b0, {1'b0, 32'h0000_0FF0});
    apply_exp("R3 no rotate keeps carry", 1'b1, 12'h0A5, 32'd0, 8'd0, 1'b1, {1'b1, 32'h0000_00A5});
    apply_exp("R3 rotate by 2 sets carry", 1'b1, 12'h1FF, 32'd0, 8'd0, 1'b0, {1'b1, 32'hC000_003F});
    // R5: field 0x332, shift right logically by rs
    apply_exp("R5 reg distance LSR", 1'b0, 12'h332, 32'hF0F0_1234, 8'd3, 1'b0,
              {1'b1, 32'h1E1E_0246});
    // R4: immediate distances per kind
    apply_exp("R4 LSL imm 4", 1'b0, {5'd4, 2'b00, 1'b0, 4'd0}, 32'h8765_4321, 8'd0, 1'b0,
              {1'b0, 32'h7654_3210});
    apply_exp("R4 ASR imm 4", 1'b0, {5'd4, 2'b10, 1'b0, 4'd0}, 32'h8765_4329, 8'd0, 1'b0,
              {1'b1, 32'hF876_5432});
    apply_exp("R4 ROR imm 8", 1'b0, {5'd8, 2'b11, 1'b0, 4'd0}, 32'h1234_5680, 8'd0, 1'b0,
              {1'b1, 32'h8012_3456});
    // R6: zero distance, every kind
    for (int k = 0; k < 4; k++) begin
      apply_exp("R6 zero imm distance", 1'b0, {5'd0, k[1:0], 1'b0, 4'd0}, 32'hDEAD_BEEF,
                8'd0, 1'b1, {1'b1, 32'hDEAD_BEEF});
      apply_exp("R6 zero reg distance", 1'b0, {4'd0, 1'b0, k[1:0], 1'b1, 4'd0}, 32'h1357_9BDF,
                8'd0, 1'b0, {1'b0, 32'h1357_9BDF});
    end
    // R7: last bit out
    apply_exp("R7 LSL 1 carry", 1'b0, {5'd1, 2'b00, 1'b0, 4'd0}, 32'h8000_0000, 8'd0, 1'b0,
              {1'b1, 32'h0});
    apply_exp("R7 LSR 31 carry", 1'b0, {4'd0, 1'b0, 2'b01, 1'b1, 4'd0}, 32'h4000_0000, 8'd31,
              1'b0, {1'b1, 32'h0});
    // R8: 32 and beyond
    apply_exp("R8 LSL 32", 1'b0, 12'h010, 32'h0000_0001, 8'd32, 1'b0, {1'b1, 32'h0});
    apply_exp("R8 LSR 32", 1'b0, 12'h030, 32'h8000_0000, 8'd32, 1'b0, {1'b1, 32'h0});
    apply_exp("R8 LSL 33", 1'b0, 12'h010, 32'hFFFF_FFFF, 8'd33, 1'b1, {1'b0, 32'h0});
    apply_exp("R8 LSR 200", 1'b0, 12'h030, 32'hFFFF_FFFF, 8'd200, 1'b1, {1'b0, 32'h0});
    // R9: sign fill
    apply_exp("R9 ASR 32 neg", 1'b0, 12'h050, 32'h8000_0000, 8'd32, 1'b0, {1'b1, 32'hFFFF_FFFF});
    apply_exp("R9 ASR 255 pos", 1'b0, 12'h050, 32'h7FFF_FFFF, 8'd255, 1'b1, {1'b0, 32'h0});
    // R10: rotate modulo 32
    apply_exp("R10 ROR 32", 1'b0, 12'h070, 32'h8000_0001, 8'd32, 1'b0, {1'b1, 32'h8000_0001});
    apply_exp("R10 ROR 36", 1'b0, 12'h070, 32'h0000_00F8, 8'd36, 1'b0, {1'b1, 32'h8000_000F});
    // R11: bit 7 ignored in register-distance form
    apply("R11 bit7 clear", 1'b0, 12'h230, 32'hCAFE_F00D, 8'd5, 1'b0);
    first = {c_out, op_out};
    apply_exp("R11 bit7 set", 1'b0, 12'h2B0, 32'hCAFE_F00D, 8'd5, 1'b0, first);

    // Random mix against the reference model
    for (int i = 0; i < N_RAND; i++) begin
      logic        s;
      logic [11:0] f;
      logic [7:0]  rs;
      s  = ($urandom % 4) == 0;
      f  = 12'($urandom);
      rs = (($urandom % 3) == 0) ? rs_pick[$urandom % 6] : 8'($urandom);
      if (s)         apply("R2 random literal", s, f, $urandom, rs, 1'($urandom));
      else if (f[4]) apply("R5 random reg distance", s, f, $urandom, rs, 1'($urandom));
      else           apply("R4 random imm distance", s, f, $urandom, rs, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule